// File: doc/BRIEF.md
# IDE Data Port Read-Ahead Unit

This unit sits between a PCI I/O target and an internal request/response channel. It speeds up programmed-I/O transfers through the primary IDE data port. It watches every write to the command port to learn whether the drive is running a read-type command. While such a command is active and read-ahead is enabled, the unit sends DWORD read requests for the data port before the host asks for them. It holds the returned DWORDs in a small buffer, so that a host read of the data port can often complete from the buffer without a trip across the internal channel.

Read-ahead keeps a fixed number of DWORDs either buffered or in flight: two or three, chosen by a configuration mode. Each DWORD the host takes from the buffer triggers one new request. Read-ahead stops at the end of a 512-byte sector. Any write to the command port discards the buffer and starts counting the sector again from zero. Every other access is forwarded unchanged as a single request. The one exception is a write to the data port: when write posting is enabled, it goes out with no response requested and completes at once.

The internal channel returns responses in the order the requests were issued. The unit never issues a forwarded request while read-ahead responses are still outstanding.

Top module: `ide_rd_prefetch`

## Requirements
- R1: After reset, io_done, io_wait, rq_valid and pf_err are 0, and no read-ahead request is issued until a read command has been written to the command port.
- R2: With cfg_pf_mode 2'b00 (off) or 2'b11 (reserved), no read-ahead request is issued. Every read of the data port (io_addr 16'h01F0) is forwarded as one request with rq_prefetch 0.
- R3: A write to the command port (io_addr 16'h01F7) takes its command byte from io_wdata[7:0]. The byte values 8'h20, 8'hC4 and 8'hE4 enable read-ahead. Any other value disables it.
- R4: With read-ahead active, buffered plus outstanding read-ahead DWORDs never exceed the priming depth: 2 for mode 2'b01 and 3 for mode 2'b10. The unit fills up to that depth after the command write. Each host read served from the buffer is followed by one replacement request.
- R5: Full-DWORD reads of the data port (io_be 4'hF) return the data of the internal data-port reads in the order those reads were issued.
- R6: At most 128 read-ahead requests (one 512-byte sector) are issued after a command write. Once the buffer is empty after that, reads of the data port are forwarded.
- R7: A write to the command port discards all buffered DWORDs and resets the sector position to zero.
- R8: A data-port read with io_be other than 4'hF while read-ahead is active is forwarded as its own request. It discards the buffer and sets pf_err, which stays 1 until reset.
- R9: A data-port read that finds the buffer empty while read-ahead responses are outstanding keeps io_wait high until the data arrives. io_done only ever follows a cycle with io_wait high.
- R10: With cfg_post_wr 1, a data-port write is issued with rq_need_rsp 0 and completes (io_done) in the cycle after it is issued. With cfg_post_wr 0, or for any other address, a write requests a response and completes only after it.
- R11: A forwarded request is issued only when no read-ahead response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pf_mode | input | 2 | Read-ahead mode: 00 off, 01 depth 2, 10 depth 3, 11 reserved (off) |
| cfg_post_wr | input | 1 | Post data-port writes |
| io_req | input | 1 | One-cycle strobe of a host I/O access (accepted when idle) |
| io_wr | input | 1 | Access is a write |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_done | output | 1 | One-cycle completion strobe |
| io_rdata | output | 32 | Read data, valid with io_done |
| io_wait | output | 1 | Access accepted and not yet complete |
| rq_valid | output | 1 | Internal request strobe |
| rq_wr | output | 1 | Internal request is a write |
| rq_addr | output | 16 | Internal request address |
| rq_be | output | 4 | Internal request byte enables |
| rq_wdata | output | 32 | Internal request write data |
| rq_need_rsp | output | 1 | Response requested |
| rq_prefetch | output | 1 | Request is a read-ahead |
| rs_valid | input | 1 | Internal response strobe |
| rs_data | input | 32 | Internal response data |
| pf_err | output | 1 | Sticky partial-read error |

## Verification
The bench models the drive as a DWORD stream, so any data returned early, late, twice or from a discarded buffer shows up as a wrong sequence number. Four edges are targeted:
- A flush that left stale DWORDs in the buffer would hand back data the host had already skipped.
- A sector counter off by one would give 127 or 129 read-ahead requests instead of 128.
- A wrong depth decode would prime the wrong number of requests for mode 01, 10 or 11.
- A partial read that did not flush would let the next full read return a stale word.

Posting is timed as well: a posted write that waited for a response, or an unposted one that did not, shows up in the completion cycle.

// File: rtl/ide_pf_pkg.sv
package ide_pf_pkg;
  localparam logic [15:0] IDE_DATA_ADDR = 16'h01F0;
  localparam logic [15:0] IDE_CMD_ADDR  = 16'h01F7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } ctl_state_e;

  // Number of DWORDs kept buffered or in flight for a mode code.
  function automatic logic [1:0] prime_depth(input logic [1:0] mode);
    case (mode)
      2'b01:   prime_depth = 2'd2;
      2'b10:   prime_depth = 2'd3;
      default: prime_depth = 2'd0;
    endcase
  endfunction

  // Command bytes that start a data-in transfer.
  function automatic logic is_read_cmd(input logic [7:0] cmd);
    is_read_cmd = (cmd == 8'h20) || (cmd == 8'hC4) || (cmd == 8'hE4);
  endfunction
endpackage

// File: rtl/ide_pf_cmd_snoop.sv
module ide_pf_cmd_snoop
  import ide_pf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  output logic       cmd_read
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_read <= 1'b0;
    else if (cmd_wr) cmd_read <= is_read_cmd(cmd_byte);
  end
endmodule

// File: rtl/ide_pf_sector.sv
module ide_pf_sector #(
  parameter int SECTOR_DW = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic full
);
  localparam int POS_W = $clog2(SECTOR_DW);
  localparam logic [POS_W-1:0] LAST = POS_W'(SECTOR_DW - 1);

  logic [POS_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pos  <= '0;
      full <= 1'b0;
    end else if (adv && !full) begin
      if (pos == LAST) begin
        pos  <= '0;
        full <= 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ide_pf_fifo.sv
module ide_pf_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    ptr_next = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dout = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/ide_rd_prefetch.sv
module ide_rd_prefetch
  import ide_pf_pkg::*;
#(
  parameter int BUF_DEPTH = 3,
  parameter int SECTOR_DW = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_pf_mode,
  input  logic        cfg_post_wr,
  input  logic        io_req,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic        io_done,
  output logic [31:0] io_rdata,
  output logic        io_wait,
  output logic        rq_valid,
  output logic        rq_wr,
  output logic [15:0] rq_addr,
  output logic [3:0]  rq_be,
  output logic [31:0] rq_wdata,
  output logic        rq_need_rsp,
  output logic        rq_prefetch,
  input  logic        rs_valid,
  input  logic [31:0] rs_data,
  output logic        pf_err
);
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1);
  localparam int FILL_W = CNT_W + 1;

  ctl_state_e        state;
  logic              l_wr;
  logic [15:0]       l_addr;
  logic [3:0]        l_be;
  logic [31:0]       l_wdata;
  logic [CNT_W-1:0]  pf_pending;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [31:0]       fifo_head;
  logic [FILL_W-1:0] fill_lvl;
  logic              cmd_read, sec_full, pf_active;
  logic              hold_data_rd, hold_pf_read, hold_bad, serve_buf;
  logic              demand_path, dem_issue, dem_posted, pf_issue;
  logic              rsp_to_buf, flush_buf, cmd_wr_ev;

  // Named internal events.
  assign pf_active    = (prime_depth(cfg_pf_mode) != 2'd0) && cmd_read;
  assign fill_lvl     = FILL_W'(fifo_cnt) + FILL_W'(pf_pending);
  assign hold_data_rd = (state == ST_HOLD) && !l_wr && (l_addr == IDE_DATA_ADDR) && pf_active;
  assign hold_pf_read = hold_data_rd && (l_be == 4'hF);
  assign hold_bad     = hold_data_rd && (l_be != 4'hF);
  assign serve_buf    = hold_pf_read && (fifo_cnt != '0);
  assign demand_path  = (state == ST_HOLD) &&
                        !(hold_pf_read && ((fifo_cnt != '0) || (pf_pending != '0)));
  assign dem_issue    = demand_path && (pf_pending == '0);
  assign dem_posted   = l_wr && (l_addr == IDE_DATA_ADDR) && cfg_post_wr;
  assign pf_issue     = (state == ST_IDLE) && pf_active && !sec_full &&
                        (fill_lvl < FILL_W'(prime_depth(cfg_pf_mode)));
  assign rsp_to_buf   = rs_valid && (state != ST_WAIT);
  assign cmd_wr_ev    = dem_issue && l_wr && (l_addr == IDE_CMD_ADDR);
  assign flush_buf    = cmd_wr_ev || (dem_issue && hold_bad);

  // Request channel.
  assign rq_valid    = dem_issue || pf_issue;
  assign rq_prefetch = pf_issue;
  assign rq_wr       = dem_issue && l_wr;
  assign rq_addr     = dem_issue ? l_addr  : IDE_DATA_ADDR;
  assign rq_be       = dem_issue ? l_be    : 4'hF;
  assign rq_wdata    = dem_issue ? l_wdata : 32'h0;
  assign rq_need_rsp = dem_issue ? !dem_posted : 1'b1;
  assign io_wait     = (state != ST_IDLE);

  ide_pf_cmd_snoop i_snoop (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr_ev),
    .cmd_byte (l_wdata[7:0]),
    .cmd_read (cmd_read)
  );

  ide_pf_sector #(.SECTOR_DW(SECTOR_DW)) i_sector (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd_wr_ev),
    .adv   (pf_issue),
    .full  (sec_full)
  );

  ide_pf_fifo #(.DEPTH(BUF_DEPTH), .W(32)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_buf),
    .push  (rsp_to_buf),
    .din   (rs_data),
    .pop   (serve_buf),
    .dout  (fifo_head),
    .count (fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      l_wr       <= 1'b0;
      l_addr     <= '0;
      l_be       <= '0;
      l_wdata    <= '0;
      io_done    <= 1'b0;
      io_rdata   <= '0;
      pf_pending <= '0;
      pf_err     <= 1'b0;
    end else begin
      io_done <= 1'b0;
      case ({pf_issue, rsp_to_buf})
        2'b10:   pf_pending <= pf_pending + CNT_W'(1);
        2'b01:   pf_pending <= pf_pending - CNT_W'(1);
        default: pf_pending <= pf_pending;
      endcase
      if (dem_issue && hold_bad) pf_err <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (io_req) begin
            l_wr    <= io_wr;
            l_addr  <= io_addr;
            l_be    <= io_be;
            l_wdata <= io_wdata;
            state   <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (serve_buf) begin
            io_done  <= 1'b1;
            io_rdata <= fifo_head;
            state    <= ST_IDLE;
          end else if (dem_issue) begin
            if (dem_posted) begin
              io_done  <= 1'b1;
              io_rdata <= '0;
              state    <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (rs_valid) begin
            io_done  <= 1'b1;
            io_rdata <= l_wr ? 32'h0 : rs_data;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ide_rd_prefetch_chk.sv
module ide_rd_prefetch_chk
  import ide_pf_pkg::*;
#(
  parameter int BUF_DEPTH = 3,
  parameter int CNT_W     = 2,
  parameter int FILL_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_pf_mode,
  input logic              io_done,
  input logic              io_wait,
  input logic              pf_err,
  input logic              rq_valid,
  input logic              rq_prefetch,
  input logic              rq_need_rsp,
  input logic [CNT_W-1:0]  pf_pending,
  input logic [FILL_W-1:0] fill_lvl,
  input logic              sec_full
);
  // R11
  demand_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rq_prefetch) |-> (pf_pending == '0));
  // R4
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_prefetch |-> (fill_lvl < FILL_W'(prime_depth(cfg_pf_mode))));
  // R4
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lvl <= FILL_W'(BUF_DEPTH));
  // R6
  sector_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_prefetch |-> !sec_full);
  // R2
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_prefetch |-> (cfg_pf_mode == 2'b01 || cfg_pf_mode == 2'b10));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_err |=> pf_err);
  // R9
  done_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |-> $past(io_wait));
  // R10
  posted_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rq_prefetch && !rq_need_rsp) |=> io_done);
endmodule

bind ide_rd_prefetch ide_rd_prefetch_chk #(
  .BUF_DEPTH (BUF_DEPTH),
  .CNT_W     (CNT_W),
  .FILL_W    (FILL_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_pf_mode (cfg_pf_mode),
  .io_done     (io_done),
  .io_wait     (io_wait),
  .pf_err      (pf_err),
  .rq_valid    (rq_valid),
  .rq_prefetch (rq_prefetch),
  .rq_need_rsp (rq_need_rsp),
  .pf_pending  (pf_pending),
  .fill_lvl    (fill_lvl),
  .sec_full    (sec_full)
);

// File: tb/test_ide_rd_prefetch.sv
`timescale 1ns/1ps
module test_ide_rd_prefetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_pf_mode = 2'b00;
  logic        cfg_post_wr = 1'b0;
  logic        io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_done, io_wait;
  logic [31:0] io_rdata;
  logic        rq_valid, rq_wr, rq_need_rsp, rq_prefetch;
  logic [15:0] rq_addr;
  logic [3:0]  rq_be;
  logic [31:0] rq_wdata;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_data = '0;
  logic        pf_err;

  int checks = 0, failures = 0, cyc = 0, lat = 3;
  int stream = 0, pf_cnt = 0, dem_cnt = 0;
  logic last_need = 1'b0;
  int   q_due[$];
  logic [31:0] q_dat[$];

  always #2 clk = ~clk;

  ide_rd_prefetch i_ide_rd_prefetch (
    .clk(clk), .rst_n(rst_n), .cfg_pf_mode(cfg_pf_mode), .cfg_post_wr(cfg_post_wr),
    .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
    .io_done(io_done), .io_rdata(io_rdata), .io_wait(io_wait),
    .rq_valid(rq_valid), .rq_wr(rq_wr), .rq_addr(rq_addr), .rq_be(rq_be),
    .rq_wdata(rq_wdata), .rq_need_rsp(rq_need_rsp), .rq_prefetch(rq_prefetch),
    .rs_valid(rs_valid), .rs_data(rs_data), .pf_err(pf_err)
  );

  function automatic logic [31:0] word(input int n);
    return 32'hD000_0000 + 32'(n);
  endfunction

  // Device model: in-order responder; data-port reads consume the stream.
  always @(negedge clk) begin
    cyc++;
    rs_valid = 1'b0;
    if (q_due.size() > 0 && q_due[0] <= cyc) begin
      rs_valid = 1'b1;
      rs_data  = q_dat[0];
      void'(q_due.pop_front());
      void'(q_dat.pop_front());
    end
    if (rst_n && rq_valid) begin
      if (rq_prefetch) pf_cnt++;
      else begin
        dem_cnt++;
        last_need = rq_need_rsp;
      end
      if (rq_need_rsp) begin
        q_due.push_back(cyc + lat);
        if (rq_wr) q_dat.push_back(32'h0);
        else if (rq_addr == 16'h01F0) begin
          q_dat.push_back(word(stream));
          stream++;
        end else q_dat.push_back(32'hBEEF_0000 | 32'(rq_addr));
      end
    end
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] rd, output int ncyc);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_addr = a; io_be = be; io_wdata = d;
    @(negedge clk);
    io_req = 1'b0;
    ncyc = 1;
    while (!io_done && ncyc < 2000) begin
      @(negedge clk);
      ncyc++;
    end
    rd = io_rdata;
    if (ncyc >= 2000) chk(1'b0, "access timeout", ncyc, 0);
  endtask

  task automatic cmd(input logic [7:0] c);
    logic [31:0] r; int n;
    access(1'b1, 16'h01F7, 4'b1000, {24'h0, c}, r, n);
  endtask

  task automatic rd_data(output logic [31:0] r);
    int n;
    access(1'b0, 16'h01F0, 4'hF, 32'h0, r, n);
  endtask

  task automatic t_reset;
    chk(!io_done && !io_wait && !rq_valid && !pf_err, "R1 reset outputs",
        {io_done, io_wait, rq_valid, pf_err}, 0);
    idle(10);
    chk(pf_cnt == 0, "R1 no read-ahead after reset", pf_cnt, 0);
  endtask

  task automatic t_off(input logic [1:0] m);
    logic [31:0] r; int p, d, s;
    cfg_pf_mode = m;
    cmd(8'h20);
    idle(20);
    p = pf_cnt; d = dem_cnt; s = stream;
    rd_data(r);
    idle(10);
    chk(pf_cnt == p, "R2 mode off/reserved no read-ahead", pf_cnt - p, 0);
    chk(dem_cnt == d + 1 && r == word(s), "R2 forwarded data read", r, word(s));
  endtask

  task automatic t_prime(input logic [1:0] m, input int exp);
    logic [31:0] r; int p;
    cfg_pf_mode = m;
    cmd(8'h00);
    idle(20);
    p = pf_cnt;
    cmd(8'h20);
    idle(30);
    chk(pf_cnt - p == exp, "R4 priming depth", pf_cnt - p, exp);
    rd_data(r);
    idle(20);
    chk(pf_cnt - p == exp + 1, "R4 one replacement per read", pf_cnt - p, exp + 1);
  endtask

  task automatic t_order;
    logic [31:0] r; int s;
    cfg_pf_mode = 2'b10;
    idle(20);
    s = stream;
    cmd(8'h20);
    for (int i = 0; i < 6; i++) begin
      rd_data(r);
      chk(r == word(s + i), "R5 in-order read data", r, word(s + i));
    end
  endtask

  task automatic t_cmds;
    logic [31:0] r; int p, d, s;
    cfg_pf_mode = 2'b01;
    p = pf_cnt; cmd(8'hC4); idle(30);
    chk(pf_cnt - p == 2, "R3 C4h enables read-ahead", pf_cnt - p, 2);
    p = pf_cnt; cmd(8'hE4); idle(30);
    chk(pf_cnt - p == 2, "R3 E4h enables read-ahead", pf_cnt - p, 2);
    p = pf_cnt; cmd(8'hEC); idle(30);
    s = stream; d = dem_cnt;
    rd_data(r); idle(10);
    chk(pf_cnt == p, "R3 other command no read-ahead", pf_cnt - p, 0);
    chk(dem_cnt == d + 1 && r == word(s), "R3 other command read forwarded", r, word(s));
  endtask

  task automatic t_sector;
    logic [31:0] r; int p, d, s, bad;
    cfg_pf_mode = 2'b01;
    idle(20);
    s = stream; p = pf_cnt; d = dem_cnt; bad = 0;
    cmd(8'h20);
    for (int i = 0; i < 130; i++) begin
      rd_data(r);
      if (r != word(s + i)) bad++;
    end
    idle(20);
    chk(bad == 0, "R6 sector data sequence", bad, 0);
    chk(pf_cnt - p == 128, "R6 read-ahead stops at sector end", pf_cnt - p, 128);
    chk(dem_cnt - d == 3, "R6 reads past sector forwarded", dem_cnt - d, 3);
    p = pf_cnt;
    cmd(8'h20);
    idle(30);
    chk(pf_cnt - p == 2, "R7 sector position reset by command write", pf_cnt - p, 2);
  endtask

  task automatic t_flush;
    logic [31:0] r; int s;
    cfg_pf_mode = 2'b10;
    cmd(8'h20);
    idle(30);
    s = stream;
    cmd(8'h20);
    rd_data(r);
    chk(r == word(s), "R7 buffered data discarded", r, word(s));
  endtask

  task automatic t_bad;
    logic [31:0] r; int s, d, n;
    cfg_pf_mode = 2'b10;
    cmd(8'h20);
    idle(30);
    chk(pf_err == 1'b0, "R8 error clear before partial read", pf_err, 0);
    s = stream; d = dem_cnt;
    access(1'b0, 16'h01F0, 4'h3, 32'h0, r, n);
    chk(r == word(s) && dem_cnt == d + 1, "R8 partial read forwarded", r, word(s));
    chk(pf_err == 1'b1, "R8 error flag set", pf_err, 1);
    rd_data(r);
    chk(r == word(s + 1), "R8 buffer flushed", r, word(s + 1));
    cmd(8'h20); idle(10);
    chk(pf_err == 1'b1, "R8 error flag sticky", pf_err, 1);
  endtask

  task automatic t_wait;
    logic [31:0] r; int s, n;
    cfg_pf_mode = 2'b10;
    lat = 20;
    idle(30);
    s = stream;
    cmd(8'h20);
    access(1'b0, 16'h01F0, 4'hF, 32'h0, r, n);
    chk(r == word(s), "R9 held read data", r, word(s));
    chk(n >= 20, "R9 wait states until data", n, 20);
    lat = 3;
    idle(80);
  endtask

  task automatic t_post;
    logic [31:0] r; int n;
    cfg_pf_mode = 2'b00;
    idle(20);
    cfg_post_wr = 1'b1;
    access(1'b1, 16'h01F0, 4'h3, 32'h1234, r, n);
    chk(last_need == 1'b0 && n <= 2, "R10 posted data write", n, 2);
    access(1'b1, 16'h01F2, 4'hC, 32'h5678, r, n);
    chk(last_need == 1'b1 && n > lat, "R10 other address not posted", n, lat + 1);
    cfg_post_wr = 1'b0;
    access(1'b1, 16'h01F0, 4'hF, 32'h9ABC, r, n);
    chk(last_need == 1'b1 && n > lat, "R10 unposted data write", n, lat + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_off(2'b00);
    t_off(2'b11);
    t_prime(2'b01, 2);
    t_prime(2'b10, 3);
    t_order;
    t_cmds;
    t_sector;
    t_flush;
    t_bad;
    t_wait;
    t_post;
    idle(10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule